// File: doc/BRIEF.md
# Multi-Mode Timer Channel Sequencer

This block is one 16-bit timer channel. It holds a counter and a data register. Software controls it with a start strobe and a stop strobe. An outside prescaler supplies a one-cycle count-clock enable, and a timer input pin reaches the block through a synchronizer and an edge detector. A mode field picks one of five ways of running. Each mode decides how the start strobe acts, where the counter is loaded from, whether the count goes up or down, and what raises the interrupt.

There are two down-counting periodic modes. In interval mode the count clock drives the counter; in event mode, detected input edges drive it. There is one free-running capture mode. There are two single-shot modes that wait for an input edge before they run: one-count and capture-plus-one-count. Outputs are the counter, the data register, a running flag and a one-cycle interrupt pulse.

Top module: `tmr_chan_seq`

## Requirements
- R1: After reset, count and data_out are 0, running is 0 and irq is 0.
- R2: A data_wr cycle copies data_in into the data register (seen on data_out). A capture in the same cycle takes precedence over the write.
- R3: Interval mode (mode=0). Start changes nothing until the next cnt_tick. That tick loads the data register into the counter, and each later tick decrements it. A tick at count 0 pulses irq and reloads from the data register.
- R4: Event mode (mode=1). Start loads the data register into the counter at once. Each detected input edge decrements the counter, and cnt_tick has no effect. An edge at count 0 pulses irq and reloads.
- R5: Capture mode (mode=2). Start changes nothing until the next cnt_tick. That tick loads 0, and each later tick increments. A detected edge copies the counter into the data register, pulses irq and restarts the counter at 0.
- R6: One-count mode (mode=3). Start while stopped enters a wait state, in which ticks do nothing. A detected edge ends the wait. The first tick after it loads the data register and later ticks decrement. A tick at 0 pulses irq and returns the channel to the wait state with the counter held. Start while running is ignored.
- R7: Capture-plus-one-count mode (mode=4). Start while stopped enters the wait state. The first tick after the trigger edge loads 0 and later ticks increment. The next detected edge copies the counter into the data register, pulses irq and returns the channel to the wait state with the counter held.
- R8: Stop clears running, freezes the counter and cancels a pending first-tick load or trigger wait. When stop and start come in the same cycle, stop wins.
- R9: The tin input passes through two synchronizer flops. edge_sel 0 detects rising edges, 1 detects falling edges, and 2 or 3 detect both. A change on tin takes effect at the third rising clock edge.
- R10: running is 1 from an accepted start until a stop, including the pending-load and wait states.
- R11: Mode codes 5 to 7 behave as interval mode.
- R12: irq is a single-cycle pulse and is raised only while the channel was running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Operating mode select |
| edge_sel | input | 2 | Timer input edge select |
| start | input | 1 | Start strobe |
| stop | input | 1 | Stop strobe |
| cnt_tick | input | 1 | Count-clock enable pulse |
| tin | input | 1 | Asynchronous timer input |
| data_wr | input | 1 | Data register write strobe |
| data_in | input | 16 | Data register write value |
| count | output | 16 | Counter value |
| data_out | output | 16 | Data register value |
| running | output | 1 | Channel enabled flag |
| irq | output | 1 | One-cycle terminal/capture interrupt |

## Verification
The bench checks that start in interval and capture mode leaves the counter alone until the first tick. A design that loads on the start write would show the new value one tick early. Event mode is fed count ticks and opposite-polarity edges, which a design with mixed trigger paths would count. The single-shot modes are checked for ticks ignored while waiting, a start ignored while running, and a return to waiting after the interrupt; a wrong design would keep counting or restart. Stop is checked on its own, together with start in the same cycle, and while a trigger wait is pending; a design that lets start win or keeps the wait alive would leave running high.

// File: rtl/tmr_chan_seq.sv
module tmr_chan_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   mode,
  input  logic [1:0]   edge_sel,
  input  logic         start,
  input  logic         stop,
  input  logic         cnt_tick,
  input  logic         tin,
  input  logic         data_wr,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] count,
  output logic [W-1:0] data_out,
  output logic         running,
  output logic         irq
);
  localparam logic [2:0] M_EVT = 3'd1, M_CAP = 3'd2, M_ONE = 3'd3, M_CAP1 = 3'd4;
  localparam logic [1:0] S_IDLE = 2'd0, S_PEND = 2'd1, S_RUN = 2'd2, S_WAIT = 2'd3;

  logic [1:0]   st;
  logic [W-1:0] cnt, dreg;
  logic [2:0]   sync;
  logic         rise, fall, edge_hit;

  assign rise     = sync[1] & ~sync[2];
  assign fall     = ~sync[1] & sync[2];
  assign edge_hit = edge_sel[1] ? (rise | fall) : (edge_sel[0] ? fall : rise);

  wire up_mode   = (mode == M_CAP) || (mode == M_CAP1);
  wire wait_mode = (mode == M_ONE) || (mode == M_CAP1);
  wire down_step = (mode == M_EVT) ? edge_hit : cnt_tick;

  assign count    = cnt;
  assign data_out = dreg;
  assign running  = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], tin};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      dreg <= '0;
      irq  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (data_wr) dreg <= data_in;
      if (stop) begin
        st <= S_IDLE;
      end else if (start && wait_mode) begin
        if (st == S_IDLE) st <= S_WAIT;
      end else if (start) begin
        if (mode == M_EVT) begin
          cnt <= dreg;
          st  <= S_RUN;
        end else begin
          st <= S_PEND;
        end
      end else begin
        case (st)
          S_WAIT: if (edge_hit) st <= S_PEND;
          S_PEND: if (cnt_tick) begin
            cnt <= up_mode ? '0 : dreg;
            st  <= S_RUN;
          end
          S_RUN: begin
            if (up_mode) begin
              if (edge_hit) begin
                dreg <= cnt;
                irq  <= 1'b1;
                if (mode == M_CAP1) st <= S_WAIT;
                else                cnt <= '0;
              end else if (cnt_tick) begin
                cnt <= cnt + 1'b1;
              end
            end else if (down_step) begin
              if (cnt == '0) begin
                irq <= 1'b1;
                if (mode == M_ONE) st <= S_WAIT;
                else               cnt <= dreg;
              end else begin
                cnt <= cnt - 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_stop_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !running);

  assert_stop_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> count == $past(count));

  assert_irq_running_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(running));

  assert_event_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop && mode == M_EVT) |=> (count == $past(data_out)) && running);

  assert_interval_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && mode == 3'd0 && cnt_tick && !start && !stop && cnt != '0)
      |=> count == $past(count) - 1'b1);

  assert_capture_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && mode == M_CAP && $past(mode) == M_CAP) |-> (data_out == $past(count)) && (count == '0));

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !start && !stop) |=> count == $past(count));
endmodule

// File: tb/tmr_chan_seq_test.sv
module tmr_chan_seq_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [1:0]  edge_sel = 2'd0;
  logic        start = 1'b0, stop = 1'b0, cnt_tick = 1'b0, tin = 1'b0, data_wr = 1'b0;
  logic [15:0] data_in = 16'd0;
  logic [15:0] count, data_out;
  logic        running, irq;
  int errors = 0, checks = 0;

  tmr_chan_seq uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .edge_sel(edge_sel), .start(start),
    .stop(stop), .cnt_tick(cnt_tick), .tin(tin), .data_wr(data_wr), .data_in(data_in),
    .count(count), .data_out(data_out), .running(running), .irq(irq));

  always #10 clk = ~clk;

  // {tick, expected irq, expected count}
  localparam logic [17:0] IVEC [6] = '{
    {1'b1, 1'b0, 16'd2}, {1'b1, 1'b0, 16'd1}, {1'b1, 1'b0, 16'd0},
    {1'b1, 1'b1, 16'd2}, {1'b0, 1'b0, 16'd2}, {1'b1, 1'b0, 16'd1}};

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) cnt_tick = 1'b1;
    @(negedge clk) cnt_tick = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk) begin data_wr = 1'b1; data_in = v; end
    @(negedge clk) data_wr = 1'b0;
  endtask

  task automatic set_in(input logic v);
    @(negedge clk) tin = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", count, 16'd0);
    chk("R1 data", data_out, 16'd0);
    chk("R1 running", {15'd0, running}, 16'd1 - 16'd1);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    wr(16'd2);
    chk("R2 data write", data_out, 16'd2);

    mode = 3'd0;
    do_start();
    chk("R3 no load before tick", count, 16'd0);
    chk("R10 running after start", {15'd0, running}, 16'd1);
    for (int i = 0; i < 6; i++) begin
      if (IVEC[i][17]) tick();
      else @(negedge clk);
      chk("R3 interval count", count, IVEC[i][15:0]);
      chk("R12 interval irq", {15'd0, irq}, {15'd0, IVEC[i][16]});
    end

    do_stop();
    chk("R8 stop clears running", {15'd0, running}, 16'd0);
    tick();
    chk("R8 counter frozen", count, 16'd1);
    @(negedge clk) begin start = 1'b1; stop = 1'b1; end
    @(negedge clk) begin start = 1'b0; stop = 1'b0; end
    chk("R8 stop beats start", {15'd0, running}, 16'd0);

    wr(16'd3);
    mode = 3'd1; edge_sel = 2'd0;
    do_start();
    chk("R4 immediate load", count, 16'd3);
    tick();
    chk("R4 tick ignored", count, 16'd3);
    set_in(1'b1); chk("R4 edge decrement", count, 16'd2);
    set_in(1'b0); chk("R9 falling ignored on rising select", count, 16'd2);
    set_in(1'b1); chk("R4 edge decrement", count, 16'd1);
    set_in(1'b0);
    set_in(1'b1); chk("R4 edge decrement", count, 16'd0);
    set_in(1'b0);
    set_in(1'b1);
    chk("R4 zero irq", {15'd0, irq}, 16'd1);
    chk("R4 reload", count, 16'd3);
    @(negedge clk);
    chk("R12 irq single cycle", {15'd0, irq}, 16'd0);
    edge_sel = 2'd2;
    set_in(1'b0); chk("R9 both edges falling", count, 16'd2);
    edge_sel = 2'd1;
    set_in(1'b1); chk("R9 rising ignored on falling select", count, 16'd2);
    set_in(1'b0); chk("R9 falling select", count, 16'd1);

    do_stop();
    mode = 3'd2; edge_sel = 2'd0;
    do_start();
    chk("R5 no load before tick", count, 16'd1);
    tick(); chk("R5 first tick loads zero", count, 16'd0);
    tick(); tick(); tick();
    chk("R5 count up", count, 16'd3);
    set_in(1'b1);
    chk("R5 capture irq", {15'd0, irq}, 16'd1);
    chk("R5 capture data", data_out, 16'd3);
    chk("R5 restart zero", count, 16'd0);
    set_in(1'b0);
    tick(); chk("R5 counts after capture", count, 16'd1);

    do_stop();
    wr(16'd2);
    mode = 3'd3;
    do_start();
    chk("R10 running while waiting", {15'd0, running}, 16'd1);
    tick(); chk("R6 tick ignored while waiting", count, 16'd1);
    set_in(1'b1); chk("R6 trigger no load", count, 16'd1);
    tick(); chk("R6 first tick loads", count, 16'd2);
    tick(); tick(); chk("R6 count down", count, 16'd0);
    tick();
    chk("R6 terminal irq", {15'd0, irq}, 16'd1);
    chk("R6 counter held", count, 16'd0);
    tick(); chk("R6 back to waiting", count, 16'd0);
    set_in(1'b0);
    set_in(1'b1);
    tick(); chk("R6 retrigger load", count, 16'd2);
    do_start();
    tick(); chk("R6 start while running ignored", count, 16'd1);

    do_stop();
    mode = 3'd4; edge_sel = 2'd2;
    do_start();
    tick(); chk("R7 tick ignored while waiting", count, 16'd1);
    set_in(1'b0);
    tick(); chk("R7 first tick loads zero", count, 16'd0);
    tick(); tick(); chk("R7 count up", count, 16'd2);
    set_in(1'b1);
    chk("R7 capture irq", {15'd0, irq}, 16'd1);
    chk("R7 capture data", data_out, 16'd2);
    tick(); chk("R7 back to waiting", count, 16'd2);

    do_stop();
    mode = 3'd3;
    do_start();
    do_stop();
    set_in(1'b0);
    tick();
    chk("R8 wait cancelled count", count, 16'd2);
    chk("R8 wait cancelled running", {15'd0, running}, 16'd0);

    wr(16'd5);
    mode = 3'd5;
    do_start();
    chk("R11 reserved no immediate load", count, 16'd2);
    tick(); chk("R11 reserved loads on tick", count, 16'd5);
    tick(); chk("R11 reserved decrements", count, 16'd4);

    report();
  end
endmodule